// File: doc/BRIEF.md
# Instruction Fetch Front-End with Static Branch Guess

This block supplies instruction words to a decode stage. It sends word-aligned addresses to an instruction memory over a request/grant/valid handshake. It keeps at most one memory access outstanding. Returned words go into a small queue whose head is presented to decode together with the address it came from. When the memory grants at once and answers one cycle after the grant, a new word reaches decode every cycle.

Decode gives the front-end three kinds of steering, each tied to the instruction it accepts. The first is an unconditional jump target. The second is a hint that the accepted instruction is a conditional branch whose flag is still unknown, together with its signed byte offset. The third, arriving later, is the resolved direction of that branch. For a hinted branch the front-end guesses at once: a forward offset is taken and a backward offset is not. It remembers the other path. If the resolved direction disagrees with the guess, it flushes whatever it fetched on the wrong path and restarts on the other path. Any access still in flight when a redirect happens is dropped when its data returns.

Top module: `sp_fetch`

## Requirements
- R1: The first cycle after synchronous reset is released presents no instruction (`dec_valid` low), and the first address requested after reset equals the parameter `RESET_PC`.
- R2: Once `imem_req` is high in a cycle where `imem_gnt` is low, `imem_req` stays high in the next cycle and `imem_addr` keeps the same value.
- R3: Every requested address has bits [1:0] equal to zero. A jump target is used with its bits [1:0] forced to zero.
- R4: With no redirect, decode receives consecutive addresses that differ by 4, each paired with exactly the word the memory returned for that address. With zero-wait grants, one-cycle returns and decode always ready, one instruction is presented every cycle.
- R5: After a grant, `imem_req` is not raised again until the cycle in which `imem_rvalid` returns the data for that grant.
- R6: While `dec_valid` is high and `dec_ready` is low, `dec_pc` and `dec_instr` hold. Once the queue of `DEPTH` entries, counting the pending access, is full, no request is issued.
- R7: When decode accepts an instruction with `jump_valid` high, no instruction is presented in the next cycle, and the next instruction delivered comes from the aligned jump target.
- R8: A hinted branch whose offset has bit 31 set is guessed not taken and fetch continues at branch address + 4. Any other offset is guessed taken and the next delivered address is (branch address + offset) aligned.
- R9: A resolution whose direction differs from the guess makes `dec_valid` low in the next cycle. The next instruction delivered then comes from the path that was not guessed.
- R10: A resolution that agrees with the guess leaves the presented instruction and the fetch stream untouched.
- R11: A wrong-guess resolution takes priority over a jump accepted in the same cycle. A jump takes priority over a branch hint on the same instruction, and that hint then opens no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Fetch request to instruction memory |
| imem_addr | output | 32 | Word-aligned fetch address |
| imem_gnt | input | 1 | Memory accepted the request this cycle |
| imem_rvalid | input | 1 | Returned word valid this cycle |
| imem_rdata | input | 32 | Returned instruction word |
| dec_valid | output | 1 | An instruction is presented to decode |
| dec_pc | output | 32 | Address of the presented instruction |
| dec_instr | output | 32 | Presented instruction word |
| dec_ready | input | 1 | Decode accepts the presented instruction |
| jump_valid | input | 1 | Accepted instruction is an unconditional jump |
| jump_target | input | 32 | Jump destination |
| hint_valid | input | 1 | Accepted instruction is a branch with unresolved flag |
| hint_offset | input | 32 | Signed byte offset of that branch |
| res_valid | input | 1 | Resolved outcome of the open branch is available |
| res_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A wrong stale flag or a lost pending bit shows up at decode within two to three cycles after a redirect, as a word from the abandoned path or as an address gap. A wrong remembered alternate path shows up as a wrong `dec_pc` on the first instruction delivered after a wrong guess. A bad queue count shows up either as a request issued during a long decode stall or as a presented instruction that changes while stalled. The bench sweeps grant delays, return latencies and stall patterns, and at each setting checks every delivered address and word against a stream it predicts from the requirements.

// File: rtl/sp_fetch_pkg.sv
package sp_fetch_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] instr;
    } fetch_entry_t;

    typedef enum logic [1:0] {
        REDIR_NONE,
        REDIR_FIX,
        REDIR_JUMP,
        REDIR_GUESS
    } redir_src_e;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

    // forward (non-negative) offsets are guessed taken
    function automatic logic guess_forward(input logic [ADDR_W-1:0] off);
        return ~off[ADDR_W-1];
    endfunction

endpackage

// File: rtl/sp_fetch_queue.sv
module sp_fetch_queue
    import sp_fetch_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  fetch_entry_t  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic          head_valid,
    output fetch_entry_t  head,
    output logic [CW-1:0] count
);

    fetch_entry_t slots [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head_valid = (count != '0);
    assign head       = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sp_fetch_guess.sv
module sp_fetch_guess
    import sp_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hint_fire,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_off,
    input  logic              res_valid,
    input  logic              res_taken,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic              mispredict,
    output logic [ADDR_W-1:0] fix_pc
);

    logic              open_q;
    logic              dir_q;
    logic [ADDR_W-1:0] alt_q;
    logic [ADDR_W-1:0] seq_pc;

    assign pred_taken  = guess_forward(br_off);
    assign pred_target = word_align(br_pc + br_off);
    assign seq_pc      = br_pc + ADDR_W'(4);
    assign mispredict  = open_q && res_valid && (res_taken != dir_q);
    assign fix_pc      = alt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            dir_q  <= 1'b0;
            alt_q  <= '0;
        end else if (hint_fire && !mispredict) begin
            open_q <= 1'b1;
            dir_q  <= pred_taken;
            alt_q  <= pred_taken ? seq_pc : pred_target;
        end else if (res_valid) begin
            open_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sp_fetch_port.sv
module sp_fetch_port
    import sp_fetch_pkg::*;
#(
    parameter int                DEPTH    = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
    localparam int               CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic [CW-1:0]     q_count,
    input  logic              pop,
    input  logic              imem_gnt,
    input  logic              imem_rvalid,
    output logic              imem_req,
    output logic [ADDR_W-1:0] imem_addr,
    output logic              push,
    output logic [ADDR_W-1:0] push_pc
);

    logic [ADDR_W-1:0] fetch_pc;
    logic [ADDR_W-1:0] hold_addr;
    logic [ADDR_W-1:0] pend_pc;
    logic              hold;
    logic              hold_stale;
    logic              pend;
    logic              pend_stale;
    logic              room;
    logic              fresh;
    logic              granted;

    assign push    = imem_rvalid && pend && !pend_stale && !redirect;
    assign push_pc = pend_pc;

    // space for the word of a new request, even if decode stalls next cycle
    always_comb begin
        room = (int'(q_count) + int'(push) - int'(pop)) < DEPTH;
    end

    assign fresh     = !hold && !redirect && (!pend || imem_rvalid) && room;
    assign imem_req  = hold || fresh;
    assign imem_addr = hold ? hold_addr : fetch_pc;
    assign granted   = imem_req && imem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc   <= word_align(RESET_PC);
            hold       <= 1'b0;
            hold_stale <= 1'b0;
            hold_addr  <= '0;
            pend       <= 1'b0;
            pend_stale <= 1'b0;
            pend_pc    <= '0;
        end else begin
            if (redirect) begin
                fetch_pc <= redir_pc;
            end else if (fresh) begin
                fetch_pc <= fetch_pc + ADDR_W'(4);
            end

            if (imem_req && !imem_gnt) begin
                hold       <= 1'b1;
                hold_addr  <= imem_addr;
                hold_stale <= (hold && hold_stale) || redirect;
            end else begin
                hold       <= 1'b0;
                hold_stale <= 1'b0;
            end

            if (granted) begin
                pend       <= 1'b1;
                pend_pc    <= imem_addr;
                pend_stale <= (hold && hold_stale) || redirect;
            end else if (imem_rvalid) begin
                pend       <= 1'b0;
                pend_stale <= 1'b0;
            end else if (redirect && pend) begin
                pend_stale <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sp_fetch.sv
module sp_fetch
    import sp_fetch_pkg::*;
#(
    parameter int                DEPTH    = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    output logic              imem_req,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic              imem_gnt,
    input  logic              imem_rvalid,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [WORD_W-1:0] dec_instr,
    input  logic              dec_ready,
    input  logic              jump_valid,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic              hint_valid,
    input  logic [ADDR_W-1:0] hint_offset,
    input  logic              res_valid,
    input  logic              res_taken
);

    localparam int CW = $clog2(DEPTH + 1);

    fetch_entry_t      head;
    fetch_entry_t      push_data;
    logic [CW-1:0]     q_count;
    logic              pop;
    logic              push;
    logic [ADDR_W-1:0] push_pc;
    logic              jump_fire;
    logic              hint_fire;
    logic              pred_taken;
    logic [ADDR_W-1:0] pred_target;
    logic              mispredict;
    logic [ADDR_W-1:0] fix_pc;
    redir_src_e        redir_src;
    logic [ADDR_W-1:0] redir_pc;
    logic              redirect;

    assign pop       = dec_valid && dec_ready;
    assign jump_fire = pop && jump_valid;
    assign hint_fire = pop && hint_valid && !jump_valid;

    always_comb begin
        redir_src = REDIR_NONE;
        redir_pc  = '0;
        if (mispredict) begin
            redir_src = REDIR_FIX;
            redir_pc  = fix_pc;
        end else if (jump_fire) begin
            redir_src = REDIR_JUMP;
            redir_pc  = word_align(jump_target);
        end else if (hint_fire && pred_taken) begin
            redir_src = REDIR_GUESS;
            redir_pc  = pred_target;
        end
    end

    assign redirect  = (redir_src != REDIR_NONE);
    assign push_data = '{pc: push_pc, instr: imem_rdata};

    sp_fetch_port #(
        .DEPTH    (DEPTH),
        .RESET_PC (RESET_PC)
    ) u_port (
        .clk         (clk),
        .rst         (rst),
        .redirect    (redirect),
        .redir_pc    (redir_pc),
        .q_count     (q_count),
        .pop         (pop),
        .imem_gnt    (imem_gnt),
        .imem_rvalid (imem_rvalid),
        .imem_req    (imem_req),
        .imem_addr   (imem_addr),
        .push        (push),
        .push_pc     (push_pc)
    );

    sp_fetch_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (push_data),
        .pop        (pop),
        .flush      (redirect),
        .head_valid (dec_valid),
        .head       (head),
        .count      (q_count)
    );

    sp_fetch_guess u_guess (
        .clk         (clk),
        .rst         (rst),
        .hint_fire   (hint_fire),
        .br_pc       (dec_pc),
        .br_off      (hint_offset),
        .res_valid   (res_valid),
        .res_taken   (res_taken),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .mispredict  (mispredict),
        .fix_pc      (fix_pc)
    );

    assign dec_pc    = head.pc;
    assign dec_instr = head.instr;

endmodule

// File: rtl/sp_fetch_chk.sv
module sp_fetch_chk (
    input logic        clk,
    input logic        rst,
    input logic        imem_req,
    input logic [31:0] imem_addr,
    input logic        imem_gnt,
    input logic        imem_rvalid,
    input logic        dec_valid,
    input logic        dec_ready,
    input logic [31:0] dec_pc,
    input logic [31:0] dec_instr,
    input logic        jump_valid,
    input logic        res_valid,
    input logic        mispredict
);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> !dec_valid); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        imem_req && !imem_gnt |=> imem_req && $stable(imem_addr)); // R2

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        imem_req |-> imem_addr[1:0] == 2'b00); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        imem_req && imem_gnt |=> !imem_req || imem_rvalid); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ready && !res_valid |=>
            dec_valid && $stable(dec_pc) && $stable(dec_instr)); // R6

    AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_ready && jump_valid |=> !dec_valid); // R7

    AST_MISPRED_FLUSH: assert property (@(posedge clk) disable iff (rst)
        mispredict |=> !dec_valid); // R9

endmodule

bind sp_fetch sp_fetch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_req    (imem_req),
    .imem_addr   (imem_addr),
    .imem_gnt    (imem_gnt),
    .imem_rvalid (imem_rvalid),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_pc      (dec_pc),
    .dec_instr   (dec_instr),
    .jump_valid  (jump_valid),
    .res_valid   (res_valid),
    .mispredict  (mispredict)
);

// File: tb/sp_fetch_test.sv
module sp_fetch_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [31:0] RST_PC = 32'h0000_0100;
    localparam int N_ACC = 38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_req;
    logic [31:0] imem_addr;
    logic        imem_gnt = 1'b0;
    logic        imem_rvalid = 1'b0;
    logic [31:0] imem_rdata = '0;
    logic        dec_valid;
    logic [31:0] dec_pc;
    logic [31:0] dec_instr;
    logic        dec_ready = 1'b0;
    logic        jump_valid = 1'b0;
    logic [31:0] jump_target = '0;
    logic        hint_valid = 1'b0;
    logic [31:0] hint_offset = '0;
    logic        res_valid = 1'b0;
    logic        res_taken = 1'b0;

    int checks = 0;
    int fails = 0;

    logic        mem_busy = 1'b0;
    int          mem_cnt = 0;
    logic [31:0] mem_addr = '0;

    always #2 clk = ~clk;

    sp_fetch #(.DEPTH(2), .RESET_PC(RST_PC)) uut (
        .clk         (clk),
        .rst         (rst),
        .imem_req    (imem_req),
        .imem_addr   (imem_addr),
        .imem_gnt    (imem_gnt),
        .imem_rvalid (imem_rvalid),
        .imem_rdata  (imem_rdata),
        .dec_valid   (dec_valid),
        .dec_pc      (dec_pc),
        .dec_instr   (dec_instr),
        .dec_ready   (dec_ready),
        .jump_valid  (jump_valid),
        .jump_target (jump_target),
        .hint_valid  (hint_valid),
        .hint_offset (hint_offset),
        .res_valid   (res_valid),
        .res_taken   (res_taken)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0] + 16'h0101};
    endfunction

    function automatic logic stall_now(input int sm, input int cyc);
        case (sm)
            1:       return (cyc % 3) == 1;
            2:       return (cyc % 5) < 2;
            3:       return (cyc >= 10) && (cyc < 26);
            default: return 1'b0;
        endcase
    endfunction

    function automatic int act_code(input int k);
        case (k)
            4:  return 1;
            8:  return 2;
            12: return 3;
            16: return 4;
            20: return 5;
            24: return 6;
            28: return 7;
            32: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cfg(input int gd, input int lat, input int sm);
        logic [31:0] exp_pc, alt_pc, p, prev_pc, prev_ins, prev_addr;
        int k = 0, cyc = 0, wt = 0, c0 = 0, idle = 0;
        logic prev_hold = 1'b0, prev_stall = 1'b0, flush_chk = 1'b0, seen_first = 1'b0;
        logic res_pend = 1'b0, res_t = 1'b0, disagree = 1'b0, prio = 1'b0;
        string tag = "R4", flush_tag = "R7", stall_tag = "R6";
        prev_pc = '0; prev_ins = '0; prev_addr = '0; alt_pc = '0; p = '0;

        rst = 1'b1;
        dec_ready = 0; jump_valid = 0; hint_valid = 0; res_valid = 0;
        imem_gnt = 0; imem_rvalid = 0; mem_busy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_pc = RST_PC;

        while (k < N_ACC && idle < 300) begin
            @(negedge clk);
            cyc++; idle++;
            jump_valid = 0; hint_valid = 0; res_valid = 0; res_taken = 0;
            dec_ready = 0; imem_gnt = 0; imem_rvalid = 0;

            if (cyc == 1) chk(!dec_valid, "R1", 32'(dec_valid), 0);

            if (mem_busy) begin
                mem_cnt--;
                if (mem_cnt == 0) begin
                    imem_rvalid = 1; imem_rdata = mem_word(mem_addr); mem_busy = 0;
                end
            end

            if (prev_stall)
                chk(dec_valid && dec_pc == prev_pc && dec_instr == prev_ins,
                    stall_tag, dec_pc, prev_pc);
            if (flush_chk) begin
                chk(!dec_valid, flush_tag, 32'(dec_valid), 0);
                flush_chk = 0;
            end
            prev_stall = 0;

            if (res_pend) begin
                res_valid = 1; res_taken = res_t; res_pend = 0;
                if (prio && dec_valid) begin
                    dec_ready = 1; jump_valid = 1; jump_target = 32'h0000_7000;
                    chk(dec_pc == exp_pc, "R8", dec_pc, exp_pc);
                    k++; idle = 0;
                end
                if (disagree) begin
                    exp_pc = alt_pc; flush_chk = 1; flush_tag = "R9";
                    tag = prio ? "R11" : "R9";
                end else begin
                    tag = "R8";
                    if (dec_valid) begin
                        prev_stall = 1; stall_tag = "R10";
                        prev_pc = dec_pc; prev_ins = dec_instr;
                    end
                end
                prio = 0; disagree = 0;
            end else begin
                dec_ready = !stall_now(sm, cyc);
                if (dec_valid && dec_ready) begin
                    p = dec_pc;
                    chk(dec_pc == exp_pc, tag, dec_pc, exp_pc);
                    chk(dec_instr == mem_word(dec_pc), "R4", dec_instr, mem_word(dec_pc));
                    if (k == 0) c0 = cyc;
                    if (k == 3 && gd == 0 && lat == 1 && sm == 0)
                        chk(cyc - c0 == 3, "R4", 32'(cyc - c0), 3);
                    tag = "R4";
                    exp_pc = p + 4;
                    case (act_code(k))
                        1: begin
                            jump_valid = 1; jump_target = 32'h2000 + 32'(k * 256);
                            exp_pc = jump_target; tag = "R7";
                            flush_chk = 1; flush_tag = "R7";
                        end
                        2: begin
                            hint_valid = 1; hint_offset = 32'h40;
                            exp_pc = p + 32'h40; res_pend = 1; res_t = 1; tag = "R8";
                        end
                        3: begin
                            hint_valid = 1; hint_offset = 32'hFFFF_FF80;
                            exp_pc = p + 4; res_pend = 1; res_t = 0; tag = "R8";
                        end
                        4: begin
                            hint_valid = 1; hint_offset = 32'h40;
                            exp_pc = p + 32'h40; res_pend = 1; res_t = 0;
                            disagree = 1; alt_pc = p + 4;
                        end
                        5: begin
                            hint_valid = 1; hint_offset = 32'hFFFF_FF80;
                            exp_pc = p + 4; res_pend = 1; res_t = 1;
                            disagree = 1; alt_pc = p - 32'h80;
                        end
                        6: begin
                            jump_valid = 1; jump_target = 32'h0000_3803;
                            exp_pc = 32'h0000_3800; tag = "R3";
                            flush_chk = 1; flush_tag = "R7";
                        end
                        7: begin
                            jump_valid = 1; jump_target = 32'h0000_4000;
                            hint_valid = 1; hint_offset = 32'h40;
                            exp_pc = 32'h0000_4000; tag = "R11";
                            flush_chk = 1; flush_tag = "R7";
                        end
                        8: begin
                            hint_valid = 1; hint_offset = 32'hFFFF_FF80;
                            exp_pc = p + 4; res_pend = 1; res_t = 1;
                            disagree = 1; prio = 1; alt_pc = p - 32'h80;
                        end
                        default: ;
                    endcase
                    k++; idle = 0;
                end else if (dec_valid) begin
                    prev_stall = 1; stall_tag = "R6";
                    prev_pc = dec_pc; prev_ins = dec_instr;
                end
            end

            #0.5;
            if (imem_req) begin
                chk(imem_addr[1:0] == 2'b00, "R3", imem_addr, {imem_addr[31:2], 2'b00});
                chk(!mem_busy, "R5", 32'(mem_busy), 0);
                if (!seen_first) begin
                    chk(imem_addr == RST_PC, "R1", imem_addr, RST_PC);
                    seen_first = 1;
                end
            end
            if (sm == 3 && cyc >= 20 && cyc < 26)
                chk(!imem_req, "R6", 32'(imem_req), 0);
            if (prev_hold)
                chk(imem_req && imem_addr == prev_addr, "R2", imem_addr, prev_addr);
            if (imem_req && wt >= gd) begin
                imem_gnt = 1; wt = 0;
                mem_busy = 1; mem_cnt = lat; mem_addr = imem_addr;
            end else if (imem_req) begin
                wt++;
            end
            prev_hold = imem_req && !imem_gnt;
            prev_addr = imem_addr;
        end
        chk(k == N_ACC, "R4", 32'(k), 32'(N_ACC));
    endtask

    initial begin
        for (int gd = 0; gd < 3; gd++)
            for (int lat = 1; lat < 3; lat++)
                for (int sm = 0; sm < 3; sm++)
                    run_cfg(gd, lat, sm);
        run_cfg(0, 1, 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule